// File: doc/BRIEF.md
# Scanned Thumbwheel Store Loader

This block fills three six-decade BCD registers from one shared 4-bit digit input. The registers hold a preset value, a presignal value and a main-signal value. The same one-hot digit-select scan that multiplexes the display also drives a bank of thumbwheel switches. In each scan slot the switch for that decade therefore puts its digit on the shared input. A strobe arrives in the middle of each slot, after the data has had time to settle. On that strobe the loader writes the nibble into the decade of the chosen register that the active digit select points to. The scan runs from the most significant decade down to the least significant one, so one full scan of six slots loads a whole register.

A 2-bit store code selects the target register. Code 0 turns loading off. The loader samples the code when a new slot opens and holds it for the rest of that slot. A code change in the middle of a slot therefore takes effect in the next slot. Digits above nine are stored as nine.

The strobe acts as the valid of a one-nibble stream. There is no ready: a scan cannot be stalled, so every valid strobe is taken in the cycle it arrives. There is no back-pressure.

Top module: `thumbwheel_store_loader`

## Requirements
- R1: While reset is asserted and after it is released, all three registers read zero until a write takes place.
- R2: The store code selects the target register: 1 writes the presignal register, 2 writes the main-signal register and 3 writes the preset register. A write changes no other register.
- R3: With store code 0 in effect for a slot, a strobe in that slot leaves all three registers unchanged.
- R4: Digit-select bit i addresses decade i, which is bits [4i+3:4i] of a register. Bit 0 is the least significant decade and bit 5 the most significant. A write changes no other decade.
- R5: A register changes only on the clock edge that samples the strobe high. The new value appears at the outputs after that edge.
- R6: The store code is sampled in the cycle in which the digit-select input differs from its value in the previous cycle. A code change later in the same slot has no effect until the digit select changes again.
- R7: A data nibble from 10 to 15 is stored as 9. Values from 0 to 9 are stored unchanged.
- R8: A strobe while the digit select is all zero, or has more than one bit set, writes nothing.
- R9: One scan of six strobed slots, from bit 5 down to bit 0 with a fixed nonzero code, loads all six decades of the selected register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| digit_sel_i | input | 6 | One-hot digit select from the scan; bit 0 is the least significant decade |
| strobe_i | input | 1 | Capture pulse in the middle of a slot (the valid of the digit stream) |
| store_code_i | input | 2 | 0 none, 1 presignal, 2 main signal, 3 preset |
| bcd_i | input | 4 | Shared digit from the thumbwheel switches |
| presig_o | output | 24 | Presignal register, six BCD decades |
| main_o | output | 24 | Main-signal register, six BCD decades |
| preset_o | output | 24 | Preset register, six BCD decades |

## Verification
A stale latched code appears as a digit in the wrong register. The error is visible on the edge after the strobe of the slot in which the code changed. A wrong digit index appears as a nibble in the wrong decade, at that same edge. A faulty clamp leaves a non-BCD nibble in a register. Because the registers feed the outputs directly, every internal error can be seen at the ports one cycle after the strobe that caused it. The exhaustive sweep compares all three registers after every slot, so an error is caught within the same slot.

// File: rtl/tsl_pkg.sv
package tsl_pkg;
  typedef enum logic [1:0] {
    CODE_NONE   = 2'd0,
    CODE_PRESIG = 2'd1,
    CODE_MAIN   = 2'd2,
    CODE_PRESET = 2'd3
  } store_code_e;

  localparam int NUM_STORES = 3;
endpackage

// File: rtl/tsl_slot_track.sv
module tsl_slot_track
  import tsl_pkg::*;
#(
  parameter int NDIG  = 6,
  localparam int IDXW = (NDIG > 1) ? $clog2(NDIG) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NDIG-1:0] digit_sel,
  input  logic [1:0]      code_in,
  output store_code_e     eff_code,
  output logic [IDXW-1:0] digit_idx,
  output logic            digit_ok
);
  logic [NDIG-1:0] prev_sel;
  store_code_e     held_code;
  logic            slot_start;

  assign slot_start = (digit_sel != prev_sel);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_sel  <= '0;
      held_code <= CODE_NONE;
    end else begin
      prev_sel <= digit_sel;
      if (slot_start) held_code <= store_code_e'(code_in);
    end
  end

  assign eff_code = slot_start ? store_code_e'(code_in) : held_code;

  always_comb begin
    digit_ok = (digit_sel != '0) && ((digit_sel & (digit_sel - 1'b1)) == '0);
    digit_idx = '0;
    for (int i = 0; i < NDIG; i++) begin
      if (digit_sel[i]) digit_idx = IDXW'(i);
    end
  end
endmodule

// File: rtl/tsl_nibble_clamp.sv
module tsl_nibble_clamp #(
  parameter int DW   = 4,
  parameter int MAXV = 9
) (
  input  logic [DW-1:0] raw,
  output logic [DW-1:0] clamped
);
  localparam logic [DW-1:0] LIMIT = DW'(MAXV);

  always_comb begin
    clamped = (raw > LIMIT) ? LIMIT : raw;
    p_bcd_range_r7: assert (clamped <= LIMIT);
  end
endmodule

// File: rtl/tsl_store_bank.sv
module tsl_store_bank
  import tsl_pkg::*;
#(
  parameter int NDIG  = 6,
  parameter int DW    = 4,
  localparam int IDXW = (NDIG > 1) ? $clog2(NDIG) : 1,
  localparam int SW   = NDIG * DW
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           wr_en,
  input  store_code_e                    wr_code,
  input  logic [IDXW-1:0]                wr_digit,
  input  logic [DW-1:0]                  wr_data,
  output logic [NUM_STORES-1:0][SW-1:0]  stores
);
  for (genvar s = 0; s < NUM_STORES; s++) begin : g_store
    for (genvar d = 0; d < NDIG; d++) begin : g_digit
      logic hit;
      assign hit = wr_en && (wr_code == store_code_e'(s + 1)) &&
                   (wr_digit == IDXW'(d));

      always_ff @(posedge clk) begin
        if (!rst_n)   stores[s][d*DW +: DW] <= '0;
        else if (hit) stores[s][d*DW +: DW] <= wr_data;
      end

      // R4 / R2: nibble not addressed by a write keeps its value
      p_untouched_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en || wr_code != store_code_e'(s + 1) || wr_digit != IDXW'(d))
        |=> $stable(stores[s][d*DW +: DW]));
    end
  end
endmodule

// File: rtl/thumbwheel_store_loader.sv
module thumbwheel_store_loader
  import tsl_pkg::*;
#(
  parameter int NDIG  = 6,
  parameter int DW    = 4,
  parameter int MAXV  = 9,
  localparam int IDXW = (NDIG > 1) ? $clog2(NDIG) : 1,
  localparam int SW   = NDIG * DW
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NDIG-1:0] digit_sel_i,
  input  logic            strobe_i,
  input  logic [1:0]      store_code_i,
  input  logic [DW-1:0]   bcd_i,
  output logic [SW-1:0]   presig_o,
  output logic [SW-1:0]   main_o,
  output logic [SW-1:0]   preset_o
);
  store_code_e                   eff_code;
  logic [IDXW-1:0]               digit_idx;
  logic                          digit_ok;
  logic [DW-1:0]                 nib;
  logic                          wr_en;
  logic [NUM_STORES-1:0][SW-1:0] stores;

  tsl_slot_track #(.NDIG(NDIG)) u_track (
    .clk(clk), .rst_n(rst_n), .digit_sel(digit_sel_i), .code_in(store_code_i),
    .eff_code(eff_code), .digit_idx(digit_idx), .digit_ok(digit_ok)
  );

  tsl_nibble_clamp #(.DW(DW), .MAXV(MAXV)) u_clamp (
    .raw(bcd_i), .clamped(nib)
  );

  assign wr_en = strobe_i && digit_ok && (eff_code != CODE_NONE);

  tsl_store_bank #(.NDIG(NDIG), .DW(DW)) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_code(eff_code),
    .wr_digit(digit_idx), .wr_data(nib), .stores(stores)
  );

  assign presig_o = stores[0];
  assign main_o   = stores[1];
  assign preset_o = stores[2];

  p_no_strobe_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe_i |=> ($stable(presig_o) && $stable(main_o) && $stable(preset_o)));

  p_idle_code_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe_i && eff_code == CODE_NONE)
    |=> ($stable(presig_o) && $stable(main_o) && $stable(preset_o)));

  p_bad_select_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe_i && $countones(digit_sel_i) != 1)
    |=> ($stable(presig_o) && $stable(main_o) && $stable(preset_o)));
endmodule

// File: tb/thumbwheel_store_loader_bench.sv
module thumbwheel_store_loader_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  digit_sel_i = '0;
  logic        strobe_i = 1'b0;
  logic [1:0]  store_code_i = '0;
  logic [3:0]  bcd_i = '0;
  logic [23:0] presig_o, main_o, preset_o;

  int total = 0;
  int bad = 0;
  bit done = 0;
  logic [23:0] exp_st [3];

  always #2 clk = ~clk;

  thumbwheel_store_loader u_thumbwheel_store_loader (
    .clk(clk), .rst_n(rst_n), .digit_sel_i(digit_sel_i), .strobe_i(strobe_i),
    .store_code_i(store_code_i), .bcd_i(bcd_i),
    .presig_o(presig_o), .main_o(main_o), .preset_o(preset_o)
  );

  task automatic check(string req);
    logic [23:0] act [3];
    act[0] = presig_o; act[1] = main_o; act[2] = preset_o;
    for (int s = 0; s < 3; s++) begin
      total++;
      if (act[s] !== exp_st[s]) begin
        bad++;
        $display("FAIL %s store%0d actual=%h expected=%h", req, s, act[s], exp_st[s]);
      end
    end
  endtask

  function automatic void model_write(int code, int dig, int val);
    int v = (val > 9) ? 9 : val;
    if (code != 0) exp_st[code-1][dig*4 +: 4] = 4'(v);
  endfunction

  // one slot: gap with no select, open slot with code, optional mid-slot change, strobe
  task automatic run_slot(logic [5:0] sel, int code, int mid_code, int val, bit do_strobe);
    @(negedge clk); digit_sel_i = '0;
    @(negedge clk); digit_sel_i = sel; store_code_i = 2'(code); bcd_i = 4'(val);
    @(negedge clk); store_code_i = 2'(mid_code);
    @(negedge clk); strobe_i = do_strobe;
    @(negedge clk); strobe_i = 1'b0;
  endtask

  initial begin
    #800000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int s = 0; s < 3; s++) exp_st[s] = '0;
    repeat (3) @(negedge clk);
    check("R1");
    rst_n = 1'b1;
    @(negedge clk);
    check("R1");

    // exhaustive sweep: code x digit x nibble (R2 R3 R4 R7)
    for (int c = 0; c < 4; c++)
      for (int d = 0; d < 6; d++)
        for (int v = 0; v < 16; v++) begin
          run_slot(6'(1 << d), c, c, v, 1'b1);
          model_write(c, d, v);
          check(c == 0 ? "R3" : (v > 9 ? "R7" : "R2/R4"));
        end

    // R5: no strobe -> no change
    run_slot(6'b000100, 1, 1, 3, 1'b0);
    check("R5");

    // R8: invalid selects
    run_slot(6'b000000, 2, 2, 5, 1'b1); check("R8");
    run_slot(6'b010001, 2, 2, 5, 1'b1); check("R8");
    run_slot(6'b111111, 3, 3, 1, 1'b1); check("R8");

    // R6: code changed mid-slot is ignored in that slot
    run_slot(6'b000010, 1, 3, 7, 1'b1);
    model_write(1, 1, 7); check("R6");
    run_slot(6'b000001, 0, 2, 4, 1'b1); // latched 0 -> nothing
    check("R6");
    // next slot picks up held code without gap
    @(negedge clk); digit_sel_i = 6'b001000; store_code_i = 2'd2; bcd_i = 4'd8;
    @(negedge clk); store_code_i = 2'd1;
    @(negedge clk); strobe_i = 1'b1;
    @(negedge clk); strobe_i = 1'b0; digit_sel_i = 6'b010000;
    model_write(2, 3, 8); check("R6");
    @(negedge clk); strobe_i = 1'b1; bcd_i = 4'd2;
    @(negedge clk); strobe_i = 1'b0;
    model_write(1, 4, 2); check("R6");

    // R9: full MSD->LSD scan into preset store, value 123456
    for (int d = 5; d >= 0; d--) begin
      @(negedge clk); digit_sel_i = 6'(1 << d); store_code_i = 2'd3; bcd_i = 4'(6 - d);
      @(negedge clk); strobe_i = 1'b1;
      @(negedge clk); strobe_i = 1'b0;
      model_write(3, d, 6 - d);
    end
    total++;
    if (preset_o !== 24'h123456) begin
      bad++;
      $display("FAIL R9 actual=%h expected=123456", preset_o);
    end
    check("R9");

    // R1 again: synchronous reset clears all
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    for (int s = 0; s < 3; s++) exp_st[s] = '0;
    check("R1");

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule